// File: doc/BRIEF.md
# I2C SCL Bit Timer

This block derives the serial clock of an I2C controller from the core clock. It also tells the transfer engine when to act on the data line. A 16-bit divider sets the clock period, and its least significant bit is ignored, so the period is always an even number of core clocks. The clock spends half of that period low and half high. The high half is measured only from the moment the sensed clock line actually reads high, so a target that stretches the clock lengthens the high phase instead of being overridden.

The block gives the engine four single-cycle strobes:
- `scl_fall` marks the start of each low phase.
- `scl_rise` marks that the line has been seen high.
- `launch_bit` comes a programmable number of core clocks after the falling edge, and tells the engine to drive the next data bit.
- `sample_bit` comes a programmable number of core clocks after the line is sensed high, and tells the engine to capture the incoming bit.

The engine starts the clock by raising `enable`. Lowering `enable` returns the line to idle at once and cancels any strobe still pending.

The divider and the delay word are captured into registers, so a change to them takes effect one core clock later. The engine is expected to set them while the block is disabled.

Top module: `scl_bit_timer`

## Requirements
- R1: While `rst` is high, and afterwards until `enable` is first seen high, `scl_out` is 1 and every strobe output is 0.
- R2: On the clock edge after `enable` is seen low, `scl_out` is 1 and all strobes are 0, and they stay that way while `enable` stays low. A launch or sample strobe that was pending when `enable` fell never appears.
- R3: `scl_out` goes low, and `scl_fall` is asserted, in the first cycle after the edge that first samples `enable` high from idle.
- R4: Without stretching, `scl_out` is low for H cycles and then high for H cycles, where H = `div_cfg[15:1]`. Bit 0 of `div_cfg` is ignored, so for example 10 and 11 both give 5 + 5.
- R5: A `div_cfg` of 0 or 1 behaves like 0xFFFE, which gives 32767 cycles per phase.
- R6: `scl_fall` is a one-cycle pulse that coincides exactly with the first low cycle of `scl_out`. Every high-to-low step of `scl_out` while enabled carries it.
- R7: The high phase counts only cycles in which `scl_sense` is 1. If the line is held low for S cycles after release, the high phase lasts H + S cycles and `scl_out` does not fall while the line is still held low.
- R8: `scl_rise` is a one-cycle pulse in the cycle after the first cycle of a high phase in which `scl_sense` is 1.
- R9: `launch_bit` pulses N cycles after the `scl_fall` cycle. N is taken from `dly_cfg[31:16]`.
- R10: `sample_bit` pulses N cycles after the first sensed-high cycle of the high phase. N is taken from `dly_cfg[15:0]`.
- R11: A delay field of 0 acts as 1.
- R12: A delay field larger than H acts as H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the serial clock; low forces idle |
| div_cfg | input | 16 | Clock divider; bit 0 ignored; 0 or 1 means 0xFFFE |
| dly_cfg | input | 32 | [31:16] launch delay after the fall, [15:0] sample delay after the rise |
| scl_sense | input | 1 | Level of the serial clock line as read back from the pad |
| scl_out | output | 1 | Driven serial clock level (1 = released) |
| scl_fall | output | 1 | One-cycle strobe on the first low cycle |
| scl_rise | output | 1 | One-cycle strobe after the line is first sensed high |
| launch_bit | output | 1 | One-cycle strobe: drive the next data bit |
| sample_bit | output | 1 | One-cycle strobe: capture the incoming data bit |

## Verification
The hardest situation to reach from the ports is a target holding the clock low after release: the driven level and the sensed level then disagree. The bench models the line as the driven level ANDed with a programmable hold-low counter. The counter reloads on every low phase, so each release is stretched by an exact number of cycles. This lets the bench predict the shifted rise strobe, the shifted sample strobe and the lengthened high phase. Dropping `enable` while a launch strobe is still pending is reached by releasing `enable` a cycle after the falling strobe, with a long launch delay programmed.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } scl_phase_e;

  localparam int NUM_DLY    = 2;
  localparam int DLY_SAMPLE = 0;  // dly_cfg low field
  localparam int DLY_LAUNCH = 1;  // dly_cfg high field
endpackage

// File: rtl/scl_cfg_norm.sv
module scl_cfg_norm
  import scl_timer_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIV_W-1:0]       div_raw,
  input  logic [2*DIV_W-1:0]     dly_raw,
  output logic [DIV_W-2:0]       half_q,
  output logic [DIV_W-2:0]       dly_q [NUM_DLY]
);
  localparam int HALF_W = DIV_W - 1;

  function automatic logic [HALF_W-1:0] fit_delay(input logic [DIV_W-1:0] raw,
                                                  input logic [HALF_W-1:0] lim);
    logic [DIV_W-1:0] nz;
    nz = (raw == '0) ? DIV_W'(1) : raw;
    if (nz > {1'b0, lim}) return lim;
    return nz[HALF_W-1:0];
  endfunction

  logic [HALF_W-1:0] half_c;
  logic [HALF_W-1:0] dly_c [NUM_DLY];

  // LSB dropped; an all-zero result selects the largest even divider
  assign half_c = (div_raw[DIV_W-1:1] == '0) ? {HALF_W{1'b1}} : div_raw[DIV_W-1:1];

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_fit
    assign dly_c[g] = fit_delay(dly_raw[g*DIV_W +: DIV_W], half_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= {HALF_W{1'b1}};
      for (int i = 0; i < NUM_DLY; i++) dly_q[i] <= HALF_W'(1);
    end else begin
      half_q <= half_c;
      for (int i = 0; i < NUM_DLY; i++) dly_q[i] <= dly_c[i];
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_timer_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [HALF_W-1:0] half,
  input  logic              scl_sense,
  output logic              scl_q,
  output logic              fall_q,
  output logic              rise_q,
  output logic              hi_first
);
  scl_phase_e        phase;
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] last;

  assign last     = half - 1'b1;
  assign hi_first = (phase == PH_HIGH) && scl_sense && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase  <= PH_IDLE;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      cnt    <= '0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          phase  <= PH_LOW;
          scl_q  <= 1'b0;
          fall_q <= 1'b1;
          cnt    <= '0;
        end
        PH_LOW: begin
          if (cnt == last) begin
            phase <= PH_HIGH;
            scl_q <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          rise_q <= hi_first;
          if (scl_sense) begin
            if (cnt == last) begin
              phase  <= PH_LOW;
              scl_q  <= 1'b0;
              fall_q <= 1'b1;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_edge_delay.sv
module scl_edge_delay #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             trig,
  input  logic [CNT_W-1:0] dly,
  output logic             pulse_q
);
  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed   <= 1'b0;
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (trig) begin
        if (dly == CNT_W'(1)) begin
          pulse_q <= 1'b1;
          armed   <= 1'b0;
        end else begin
          armed <= 1'b1;
          cnt   <= CNT_W'(1);
        end
      end else if (armed) begin
        if (cnt == dly - 1'b1) begin
          pulse_q <= 1'b1;
          armed   <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_bit_timer.sv
module scl_bit_timer
  import scl_timer_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [DIV_W-1:0]   div_cfg,
  input  logic [2*DIV_W-1:0] dly_cfg,
  input  logic               scl_sense,
  output logic               scl_out,
  output logic               scl_fall,
  output logic               scl_rise,
  output logic               launch_bit,
  output logic               sample_bit
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] dly_n [NUM_DLY];
  logic              trig  [NUM_DLY];
  logic              pulse [NUM_DLY];
  logic              fall_w;
  logic              hi_first;

  scl_cfg_norm #(.DIV_W(DIV_W)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .div_raw (div_cfg),
    .dly_raw (dly_cfg),
    .half_q  (half),
    .dly_q   (dly_n)
  );

  scl_phase_gen #(.HALF_W(HALF_W)) i_phase (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .half      (half),
    .scl_sense (scl_sense),
    .scl_q     (scl_out),
    .fall_q    (fall_w),
    .rise_q    (scl_rise),
    .hi_first  (hi_first)
  );

  assign trig[DLY_LAUNCH] = fall_w;
  assign trig[DLY_SAMPLE] = hi_first;

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
    scl_edge_delay #(.CNT_W(HALF_W)) i_dly (
      .clk     (clk),
      .rst     (rst),
      .clear   (!enable),
      .trig    (trig[g]),
      .dly     (dly_n[g]),
      .pulse_q (pulse[g])
    );
  end

  assign scl_fall   = fall_w;
  assign launch_bit = pulse[DLY_LAUNCH];
  assign sample_bit = pulse[DLY_SAMPLE];
endmodule

// File: rtl/scl_bit_timer_chk.sv
module scl_bit_timer_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_sense,
  input logic scl_out,
  input logic scl_fall,
  input logic scl_rise,
  input logic launch_bit,
  input logic sample_bit
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_out && !scl_fall && !scl_rise && !launch_bit && !sample_bit)); // R2

  AST_FALL_MARKS_DROP: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> $fell(scl_out)); // R6

  AST_DROP_MARKED: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_out) |-> scl_fall); // R6

  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && scl_out && !scl_sense) |=> scl_out); // R7

  AST_RISE_AFTER_SENSE: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> $past(scl_sense && scl_out)); // R8

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    scl_rise |=> !scl_rise); // R8
endmodule

bind scl_bit_timer scl_bit_timer_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .scl_sense  (scl_sense),
  .scl_out    (scl_out),
  .scl_fall   (scl_fall),
  .scl_rise   (scl_rise),
  .launch_bit (launch_bit),
  .sample_bit (sample_bit)
);

// File: tb/test_scl_bit_timer.sv
module test_scl_bit_timer;
  localparam int LIMIT = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] div_cfg = 16'd10;
  logic [31:0] dly_cfg = 32'h0001_0001;
  logic        scl_sense;
  logic        scl_out, scl_fall, scl_rise, launch_bit, sample_bit;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int stretch_n = 0;
  int hold_cnt = 0;
  bit prev_scl = 1'b1;

  int fall_t[4], rise_t[4], lau_t[4], sam_t[4], lo_t[4], hi_t[4];
  int nf, nr, nl, ns, nlo, nhi;

  always #2 clk = ~clk;  // 250 MHz

  assign scl_sense = scl_out && (hold_cnt == 0);

  scl_bit_timer i_scl_bit_timer (
    .clk(clk), .rst(rst), .enable(enable), .div_cfg(div_cfg), .dly_cfg(dly_cfg),
    .scl_sense(scl_sense), .scl_out(scl_out), .scl_fall(scl_fall), .scl_rise(scl_rise),
    .launch_bit(launch_bit), .sample_bit(sample_bit)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == LIMIT) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // event monitor and line model
  always @(negedge clk) begin
    if (scl_fall   && nf < 4) begin fall_t[nf] = cyc; nf = nf + 1; end
    if (scl_rise   && nr < 4) begin rise_t[nr] = cyc; nr = nr + 1; end
    if (launch_bit && nl < 4) begin lau_t[nl]  = cyc; nl = nl + 1; end
    if (sample_bit && ns < 4) begin sam_t[ns]  = cyc; ns = ns + 1; end
    if (prev_scl && !scl_out && nlo < 4) begin lo_t[nlo] = cyc; nlo = nlo + 1; end
    if (!prev_scl && scl_out && nhi < 4) begin hi_t[nhi] = cyc; nhi = nhi + 1; end
    prev_scl = scl_out;
    if (!scl_out) hold_cnt = stretch_n + 1;
    else if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    nf = 0; nr = 0; nl = 0; ns = 0; nlo = 0; nhi = 0;
  endtask

  // one enabled run; offsets are relative to the first low / high cycle
  task automatic measure(input logic [15:0] dv, input logic [31:0] dl, input int s,
                         input bit short_run, output int lo, output int hi,
                         output int loff, output int roff, output int soff,
                         output int start_off, output int fall_off);
    int en_c;
    @(negedge clk);
    enable = 1'b0; div_cfg = dv; dly_cfg = dl; stretch_n = s;
    repeat (4) @(negedge clk);
    @(posedge clk);
    clear_counts();
    @(negedge clk);
    enable = 1'b1;
    en_c = cyc;
    if (short_run) begin
      do @(posedge clk); while (nhi < 1);
    end else begin
      do @(posedge clk); while (nlo < 2 || ns < 1 || nr < 1 || nl < 1);
    end
    lo        = hi_t[0] - lo_t[0];
    hi        = short_run ? 0 : lo_t[1] - hi_t[0];
    loff      = (nl > 0) ? lau_t[0] - fall_t[0] : -1;
    roff      = (nr > 0) ? rise_t[0] - hi_t[0] : -1;
    soff      = (ns > 0) ? sam_t[0] - hi_t[0] : -1;
    start_off = lo_t[0] - en_c;
    fall_off  = fall_t[0] - lo_t[0];
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 scl_out in reset", scl_out, 1);
    chk("R1 strobes in reset", scl_fall | scl_rise | launch_bit | sample_bit, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 scl_out after reset", scl_out, 1);
    chk("R1 strobes after reset", scl_fall | scl_rise | launch_bit | sample_bit, 0);
  endtask

  task automatic t_basic();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd10, {16'd2, 16'd3}, 0, 1'b0, lo, hi, lf, rf, sf, st, fo);
    chk("R3 first low cycle after enable", st, 1);
    chk("R6 scl_fall on first low cycle", fo, 0);
    chk("R6 one fall strobe per low phase", nf, nlo);
    chk("R4 low phase div 10", lo, 5);
    chk("R4 high phase div 10", hi, 5);
    chk("R9 launch delay 2", lf, 2);
    chk("R8 rise strobe offset", rf, 1);
    chk("R10 sample delay 3", sf, 3);
  endtask

  task automatic t_odd_zero();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd11, 32'h0000_0000, 0, 1'b0, lo, hi, lf, rf, sf, st, fo);
    chk("R4 low phase div 11", lo, 5);
    chk("R4 high phase div 11", hi, 5);
    chk("R11 zero launch delay", lf, 1);
    chk("R11 zero sample delay", sf, 1);
  endtask

  task automatic t_clamp();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd6, {16'd9, 16'd100}, 0, 1'b0, lo, hi, lf, rf, sf, st, fo);
    chk("R4 low phase div 6", lo, 3);
    chk("R12 launch clamped to half", lf, 3);
    chk("R12 sample clamped to half", sf, 3);
  endtask

  task automatic t_stretch();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd8, {16'd1, 16'd2}, 7, 1'b0, lo, hi, lf, rf, sf, st, fo);
    chk("R7 low phase unaffected", lo, 4);
    chk("R7 high phase stretched", hi, 11);
    chk("R8 rise after stretch", rf, 8);
    chk("R10 sample after stretch", sf, 9);
    chk("R9 launch delay 1", lf, 1);
    stretch_n = 0;
  endtask

  task automatic t_min_div();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd2, 32'h0000_0000, 0, 1'b0, lo, hi, lf, rf, sf, st, fo);
    chk("R4 low phase div 2", lo, 1);
    chk("R4 high phase div 2", hi, 1);
    chk("R9 launch at div 2", lf, 1);
    chk("R10 sample at div 2", sf, 1);
  endtask

  task automatic t_max_div();
    int lo, hi, lf, rf, sf, st, fo;
    measure(16'd0, 32'h0001_0001, 0, 1'b1, lo, hi, lf, rf, sf, st, fo);
    chk("R5 div 0 low phase", lo, 32767);
    measure(16'd1, 32'h0001_0001, 0, 1'b1, lo, hi, lf, rf, sf, st, fo);
    chk("R5 div 1 low phase", lo, 32767);
  endtask

  task automatic t_disable();
    int nlo_b, nr_b, ns_b, nf_b, bad_lo;
    @(negedge clk);
    enable = 1'b0; div_cfg = 16'd20; dly_cfg = {16'd8, 16'd1}; stretch_n = 0;
    repeat (4) @(negedge clk);
    @(posedge clk);
    clear_counts();
    @(negedge clk);
    enable = 1'b1;
    do @(posedge clk); while (nf < 1);
    @(negedge clk);
    enable = 1'b0;  // launch still pending (due 8 cycles after the fall)
    @(negedge clk);
    chk("R2 scl_out high after disable", scl_out, 1);
    nlo_b = nlo; nr_b = nr; ns_b = ns; nf_b = nf;
    bad_lo = 0;
    repeat (40) begin
      @(negedge clk);
      if (!scl_out) bad_lo = bad_lo + 1;
    end
    chk("R2 pending launch cancelled", nl, 0);
    chk("R2 no strobes while disabled", (nr - nr_b) + (ns - ns_b) + (nf - nf_b) + (nlo - nlo_b), 0);
    chk("R2 line stays idle high", bad_lo, 0);
  endtask

  initial begin
    clear_counts();
    t_reset();
    t_basic();
    t_odd_zero();
    t_clamp();
    t_stretch();
    t_min_div();
    t_disable();
    t_max_div();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule